// File: doc/BRIEF.md
# UART FIFO Control with Per-Field Shadow Registers

This block is the buffering and threshold logic of a UART. It contains a transmit FIFO and a receive FIFO, each 16 entries of 8 bits. A write-only control register sets four fields at once: FIFO enable, receive DMA mode, transmit empty threshold and receive threshold. Three shadow registers let software rewrite one field alone, without keeping a copy of the control register. The host side pushes transmit bytes and pops receive bytes. The serializer pops transmit bytes and the deserializer pushes receive bytes.

Each FIFO's fill level is compared against the threshold that software selected. The results drive a received-data-available interrupt, a transmit-empty interrupt that only works when the surrounding UART has enabled threshold mode, and an active-low receive DMA request. Clearing the enable resets both FIFOs.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, every field reads 0, both levels are 0, both overrun flags are 0, the received-data-available interrupt is low and the DMA request output is high.
- R2: A write to address 0 sets four fields in one cycle. Bit 0 is the enable, bit 3 is the DMA mode, bits 5:4 are the transmit trigger and bits 7:6 are the receive trigger. Reading address 0 returns 0.
- R3: A write to address 1 (bit 0), address 2 (bits 1:0) or address 3 (bits 1:0) changes only the enable, the receive trigger or the transmit trigger, in that order. Reading those addresses returns the field's current value, zero-extended, whichever path last wrote it.
- R4: A write that takes the enable from 1 to 0 empties both FIFOs and clears both overrun flags on that edge. While the enable is 0, pushes are dropped.
- R5: Each FIFO returns bytes in the order they were pushed. Its level counts the entries it holds. Popped data appears on the pop-data output one cycle after the pop.
- R6: A push into a full FIFO with no pop is dropped and sets a sticky overrun flag. A push and a pop in the same cycle on a full FIFO are both accepted, and the level stays 16.
- R7: A pop from an empty FIFO leaves the level at 0 and keeps the previous pop data.
- R8: The received-data-available interrupt is high while the receive level is at least the threshold for the receive trigger: 00=1, 01=4, 10=8, 11=14.
- R9: The transmit-empty interrupt is high while threshold mode is on and the transmit level is at most the threshold for the transmit trigger: 00=0, 01=2, 10=4, 11=8.
- R10: The DMA request output is low only when DMA mode is 1 and the receive level is at least the receive threshold. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| txThrMode | input | 1 | Transmit threshold interrupt mode active |
| txPush | input | 1 | Host pushes a transmit byte |
| txPushData | input | 8 | Transmit byte |
| txPop | input | 1 | Serializer pops a transmit byte |
| txPopData | output | 8 | Last popped transmit byte |
| rxPush | input | 1 | Deserializer pushes a receive byte |
| rxPushData | input | 8 | Receive byte |
| rxPop | input | 1 | Host pops a receive byte |
| rxPopData | output | 8 | Last popped receive byte |
| txLevel | output | 5 | Transmit FIFO fill level |
| rxLevel | output | 5 | Receive FIFO fill level |
| txOverrun | output | 1 | Sticky transmit overrun flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| rxAvailIrq | output | 1 | Received-data-available interrupt |
| txEmptyIrq | output | 1 | Transmit-empty threshold interrupt |
| rxDmaReqN | output | 1 | Receive DMA request, active low |

## Verification
A push and a pop can reach the same FIFO in the same cycle, and the outcome depends on the level. At full, both must be accepted with no overrun. At empty, the pop is ignored and the push is taken. The bench provokes both cases in two ways: directed pushes and pops that hold a FIFO at each bound, and long random push/pop streams whose bias alternates between filling and draining. A queue model, updated cycle by cycle from the requirements, predicts the level, the overrun flag and the pop data after every edge, and the bench compares the design's outputs against it.

// File: rtl/uart_fifo_pkg.sv
`timescale 1ns/1ps
package uart_fifo_pkg;
  localparam int FIFO_DEPTH = 16;
  localparam int DATA_W     = 8;
  localparam int REG_AW     = 3;
  localparam int REG_DW     = 8;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_SH_EN  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_SH_RXT = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_SH_TXT = 3'd3;

  typedef struct packed {
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobeT;

  // receive threshold: level must reach this value
  function automatic int rxThresholdOf(input logic [1:0] trig, input int depth);
    case (trig)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // transmit threshold: level must be at or below this value
  function automatic int txThresholdOf(input logic [1:0] trig, input int depth);
    case (trig)
      2'b00:   return 0;
      2'b01:   return 2;
      2'b10:   return depth / 4;
      default: return depth / 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_buf.sv
`timescale 1ns/1ps
module uart_fifo_buf #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [LW-1:0]    level,
  output logic             overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop, overrunSet;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    doPop      = pop && !flush && (level != '0);
    doPush     = push && !flush && ((level != LW'(DEPTH)) || doPop);
    overrunSet = push && !flush && !doPush;
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
      popData <= '0;
    end else if (flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop) begin
        rdPtr   <= nextPtr(rdPtr);
        popData <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (overrunSet) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_fifo_dp.sv
`timescale 1ns/1ps
module uart_fifo_dp import uart_fifo_pkg::*; #(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int DW    = DATA_W,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    strobe,
  input  logic [DW-1:0] txPushData,
  input  logic [DW-1:0] rxPushData,
  output logic [DW-1:0] txPopData,
  output logic [DW-1:0] rxPopData,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic          txOverrun,
  output logic          rxOverrun
);
  uart_fifo_buf #(.WIDTH(DW), .DEPTH(DEPTH), .LW(LW)) uTxBuf (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.flush),
    .push     (strobe.txPush),
    .pushData (txPushData),
    .pop      (strobe.txPop),
    .popData  (txPopData),
    .level    (txLevel),
    .overrun  (txOverrun)
  );

  uart_fifo_buf #(.WIDTH(DW), .DEPTH(DEPTH), .LW(LW)) uRxBuf (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.flush),
    .push     (strobe.rxPush),
    .pushData (rxPushData),
    .pop      (strobe.rxPop),
    .popData  (rxPopData),
    .level    (rxLevel),
    .overrun  (rxOverrun)
  );
endmodule

// File: rtl/uart_fifo_ctl.sv
`timescale 1ns/1ps
module uart_fifo_ctl import uart_fifo_pkg::*; #(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  logic              txThrMode,
  input  logic              txPush,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic [LW-1:0]     txLevel,
  input  logic [LW-1:0]     rxLevel,
  output fifoStrobeT        strobe,
  output logic              fifoEn,
  output logic              dmaMode,
  output logic [1:0]        rxTrig,
  output logic [1:0]        txTrig,
  output logic              rxAvailIrq,
  output logic              txEmptyIrq,
  output logic              rxDmaReqN
);
  logic       enNext, dmaNext;
  logic [1:0] rxTrigNext, txTrigNext;
  logic       rxHit, txHit;
  logic       unusedCtrlBits;

  assign unusedCtrlBits = ^{regWrData[2:1]};

  always_comb begin
    enNext     = fifoEn;
    dmaNext    = dmaMode;
    rxTrigNext = rxTrig;
    txTrigNext = txTrig;
    if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL: begin
          enNext     = regWrData[0];
          dmaNext    = regWrData[3];
          txTrigNext = regWrData[5:4];
          rxTrigNext = regWrData[7:6];
        end
        ADDR_SH_EN:  enNext     = regWrData[0];
        ADDR_SH_RXT: rxTrigNext = regWrData[1:0];
        ADDR_SH_TXT: txTrigNext = regWrData[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      dmaMode <= 1'b0;
      rxTrig  <= 2'b00;
      txTrig  <= 2'b00;
    end else begin
      fifoEn  <= enNext;
      dmaMode <= dmaNext;
      rxTrig  <= rxTrigNext;
      txTrig  <= txTrigNext;
    end
  end

  always_comb begin
    strobe.flush  = fifoEn && !enNext;
    strobe.txPush = txPush && fifoEn;
    strobe.rxPush = rxPush && fifoEn;
    strobe.txPop  = txPop;
    strobe.rxPop  = rxPop;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_SH_EN:  regRdData[0]   = fifoEn;
      ADDR_SH_RXT: regRdData[1:0] = rxTrig;
      ADDR_SH_TXT: regRdData[1:0] = txTrig;
      default: ;
    endcase
  end

  always_comb begin
    rxHit      = int'(rxLevel) >= rxThresholdOf(rxTrig, DEPTH);
    txHit      = int'(txLevel) <= txThresholdOf(txTrig, DEPTH);
    rxAvailIrq = rxHit;
    txEmptyIrq = txThrMode && txHit;
    rxDmaReqN  = !(dmaMode && rxHit);
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_ctrl import uart_fifo_pkg::*; #(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int DW    = DATA_W,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  logic              txThrMode,
  input  logic              txPush,
  input  logic [DW-1:0]     txPushData,
  input  logic              txPop,
  output logic [DW-1:0]     txPopData,
  input  logic              rxPush,
  input  logic [DW-1:0]     rxPushData,
  input  logic              rxPop,
  output logic [DW-1:0]     rxPopData,
  output logic [LW-1:0]     txLevel,
  output logic [LW-1:0]     rxLevel,
  output logic              txOverrun,
  output logic              rxOverrun,
  output logic              rxAvailIrq,
  output logic              txEmptyIrq,
  output logic              rxDmaReqN
);
  fifoStrobeT strobe;
  logic       fifoEn, dmaMode;
  logic [1:0] rxTrig, txTrig;

  uart_fifo_ctl #(.DEPTH(DEPTH), .LW(LW)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .txThrMode  (txThrMode),
    .txPush     (txPush),
    .txPop      (txPop),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .strobe     (strobe),
    .fifoEn     (fifoEn),
    .dmaMode    (dmaMode),
    .rxTrig     (rxTrig),
    .txTrig     (txTrig),
    .rxAvailIrq (rxAvailIrq),
    .txEmptyIrq (txEmptyIrq),
    .rxDmaReqN  (rxDmaReqN)
  );

  uart_fifo_dp #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txPushData (txPushData),
    .rxPushData (rxPushData),
    .txPopData  (txPopData),
    .rxPopData  (rxPopData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txOverrun  (txOverrun),
    .rxOverrun  (rxOverrun)
  );
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          fifoEn,
  input logic          dmaMode,
  input logic          txThrMode,
  input logic          txPush,
  input logic          txPop,
  input logic          rxPush,
  input logic          rxPop,
  input logic [DW-1:0] rxPopData,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel,
  input logic          rxOverrun,
  input logic          txEmptyIrq,
  input logic          rxDmaReqN
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txLevel) <= DEPTH) && (int'(rxLevel) <= DEPTH)); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoEn) |-> (txLevel == '0) && (rxLevel == '0) && !rxOverrun); // R4

  AST_DISABLED_PUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && txPush && !txPop) |=> txLevel == $past(txLevel)); // R4

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && !regWrEn && int'(rxLevel) == DEPTH && rxPush && !rxPop)
      |=> (int'(rxLevel) == DEPTH) && rxOverrun); // R6

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && rxLevel == '0 && rxPop && !rxPush)
      |=> (rxLevel == '0) && $stable(rxPopData)); // R7

  AST_TX_IRQ_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !txThrMode |-> !txEmptyIrq); // R9

  AST_DMA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !dmaMode |-> rxDmaReqN); // R10
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .fifoEn     (fifoEn),
  .dmaMode    (dmaMode),
  .txThrMode  (txThrMode),
  .txPush     (txPush),
  .txPop      (txPop),
  .rxPush     (rxPush),
  .rxPop      (rxPop),
  .rxPopData  (rxPopData),
  .txLevel    (txLevel),
  .rxLevel    (rxLevel),
  .rxOverrun  (rxOverrun),
  .txEmptyIrq (txEmptyIrq),
  .rxDmaReqN  (rxDmaReqN)
);

// File: tb/sim_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       txThrMode = 1'b0;
  logic       txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txPushData = '0, rxPushData = '0;
  logic [7:0] txPopData, rxPopData;
  logic [4:0] txLevel, rxLevel;
  logic       txOverrun, rxOverrun, rxAvailIrq, txEmptyIrq, rxDmaReqN;

  int checks = 0;
  int errors = 0;

  // model state
  bit         mEn, mDma;
  bit   [1:0] mTxT, mRxT;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit         txOvr, rxOvr;
  logic [7:0] txPd, rxPd;

  always #4 clk = ~clk;

  uart_fifo_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txThrMode(txThrMode),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .txLevel(txLevel), .rxLevel(rxLevel), .txOverrun(txOverrun), .rxOverrun(rxOverrun),
    .rxAvailIrq(rxAvailIrq), .txEmptyIrq(txEmptyIrq), .rxDmaReqN(rxDmaReqN)
  );

  function automatic int rxThr(input bit [1:0] t);
    case (t) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic int txThr(input bit [1:0] t);
    case (t) 2'd0: return 0; 2'd1: return 2; 2'd2: return 4; default: return 8; endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelFifo(ref logic [7:0] q[$], ref bit ovr, ref logic [7:0] pd,
                           input bit push, input logic [7:0] d, input bit pop,
                           input bit fl, input bit en);
    bit didPop;
    if (fl) begin
      q.delete();
      ovr = 1'b0;
    end else begin
      didPop = pop && (q.size() > 0);
      if (didPop) pd = q.pop_front();
      if (push && en) begin
        if (q.size() < 16) q.push_back(d);
        else ovr = 1'b1;
      end
    end
  endtask

  task automatic compareAll();
    chk("R5", "txLevel", int'(txLevel), txQ.size());
    chk("R5", "rxLevel", int'(rxLevel), rxQ.size());
    chk("R6", "txOverrun", int'(txOverrun), int'(txOvr));
    chk("R6", "rxOverrun", int'(rxOverrun), int'(rxOvr));
    chk("R5", "txPopData", int'(txPopData), int'(txPd));
    chk("R5", "rxPopData", int'(rxPopData), int'(rxPd));
    chk("R8", "rxAvailIrq", int'(rxAvailIrq), int'(rxQ.size() >= rxThr(mRxT)));
    chk("R9", "txEmptyIrq", int'(txEmptyIrq),
        int'(txThrMode && (txQ.size() <= txThr(mTxT))));
    chk("R10", "rxDmaReqN", int'(rxDmaReqN),
        int'(!(mDma && (rxQ.size() >= rxThr(mRxT)))));
  endtask

  // one clock: model the edge from the driven inputs, then compare
  task automatic step();
    bit nEn, fl;
    nEn = mEn;
    if (regWrEn) begin
      case (regAddr)
        3'd0: begin
          nEn = regWrData[0]; mDma = regWrData[3];
          mTxT = regWrData[5:4]; mRxT = regWrData[7:6];
        end
        3'd1: nEn = regWrData[0];
        3'd2: mRxT = regWrData[1:0];
        3'd3: mTxT = regWrData[1:0];
        default: ;
      endcase
    end
    fl = mEn && !nEn;
    modelFifo(txQ, txOvr, txPd, txPush, txPushData, txPop, fl, mEn);
    modelFifo(rxQ, rxOvr, rxPd, rxPush, rxPushData, rxPop, fl, mEn);
    mEn = nEn;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [2:0] a, input int exp);
    regAddr = a;
    #1;
    chk(req, "regRdData", int'(regRdData), exp);
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d;
    step();
    rxPush = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL R5 watchdog: actual timeout expected completion");
    checks++;
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    txThrMode = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "txLevel", int'(txLevel), 0);
    chk("R1", "rxLevel", int'(rxLevel), 0);
    chk("R1", "rxOverrun", int'(rxOverrun), 0);
    chk("R1", "rxAvailIrq", int'(rxAvailIrq), 0);
    chk("R1", "rxDmaReqN", int'(rxDmaReqN), 1);
    readChk("R1", 3'd1, 0);
    readChk("R1", 3'd2, 0);
    readChk("R1", 3'd3, 0);
    @(negedge clk);

    // R2 full control write
    wr(3'd0, 8'b1011_1001);
    readChk("R2", 3'd1, 1);
    readChk("R2", 3'd2, 2);
    readChk("R2", 3'd3, 3);
    readChk("R2", 3'd0, 0);

    // R3 single-field shadow writes
    wr(3'd2, 8'hFD);
    readChk("R3", 3'd2, 1);
    readChk("R3", 3'd3, 3);
    readChk("R3", 3'd1, 1);
    wr(3'd3, 8'hFE);
    readChk("R3", 3'd3, 2);
    readChk("R3", 3'd2, 1);
    wr(3'd1, 8'hFF);
    readChk("R3", 3'd1, 1);

    // R8 / R10 each receive trigger encoding, DMA mode on
    wr(3'd0, 8'h09);
    for (int t = 0; t < 4; t++) begin
      wr(3'd1, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd2, 8'(t));
      for (int k = 0; k < rxThr(2'(t)) - 1; k++) pushRx(8'(k + 16 * t));
      chk("R8", "rxAvailIrq below threshold", int'(rxAvailIrq), 0);
      chk("R10", "rxDmaReqN below threshold", int'(rxDmaReqN), 1);
      pushRx(8'hA0 + 8'(t));
      chk("R8", "rxAvailIrq at threshold", int'(rxAvailIrq), 1);
      chk("R10", "rxDmaReqN at threshold", int'(rxDmaReqN), 0);
    end

    // R6 full receive FIFO
    while (rxQ.size() < 16) pushRx(8'h33);
    pushRx(8'h44);
    chk("R6", "rxLevel after drop", int'(rxLevel), 16);
    chk("R6", "rxOverrun set", int'(rxOverrun), 1);
    rxPop = 1'b1;
    pushRx(8'h55);
    rxPop = 1'b0;
    chk("R6", "rxLevel push+pop at full", int'(rxLevel), 16);

    // R4 flush on disable, pushes dropped while disabled
    wr(3'd0, 8'h08);
    chk("R4", "rxLevel after flush", int'(rxLevel), 0);
    chk("R4", "rxOverrun after flush", int'(rxOverrun), 0);
    pushRx(8'h66);
    txPush = 1'b1; txPushData = 8'h77; step(); txPush = 1'b0;
    chk("R4", "rxLevel disabled push", int'(rxLevel), 0);
    chk("R4", "txLevel disabled push", int'(txLevel), 0);
    wr(3'd1, 8'h01);

    // R7 pop from empty keeps data
    pushRx(8'h5A);
    rxPop = 1'b1; step();
    chk("R5", "rxPopData after pop", int'(rxPopData), 8'h5A);
    step(); rxPop = 1'b0;
    chk("R7", "rxPopData empty pop", int'(rxPopData), 8'h5A);
    chk("R7", "rxLevel empty pop", int'(rxLevel), 0);

    // R10 DMA mode off keeps request high
    wr(3'd0, 8'h01);
    pushRx(8'h01);
    chk("R10", "rxDmaReqN dma off", int'(rxDmaReqN), 1);

    // R9 threshold mode off
    txThrMode = 1'b0;
    step();
    chk("R9", "txEmptyIrq mode off", int'(txEmptyIrq), 0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      bit fill;
      fill = ((c / 150) % 2) == 0;
      txThrMode  = ($urandom % 4) != 0;
      txPush     = fill ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
      txPop      = fill ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
      rxPush     = fill ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
      rxPop      = fill ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
      txPushData = 8'($urandom);
      rxPushData = 8'($urandom);
      regWrEn    = ($urandom % 50) == 0;
      regAddr    = 3'($urandom % 5);
      regWrData  = 8'($urandom);
      if (($urandom % 6) != 0) regWrData[0] = 1'b1;
      step();
    end
    regWrEn = 1'b0; txPush = 1'b0; txPop = 1'b0; rxPush = 1'b0; rxPop = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule